// File: doc/BRIEF.md
# Software Reset Pulse Generator

This block holds one byte-wide control register on a configuration bus. The register has three fields. The first is a self-clearing trigger: writing 1 to it drives a timed, active-low reset pulse onto both the PCI reset output and the CPU reset output. The second is a stored flag that enables delayed transactions, which other logic reads. The third is a select that steers processor reset requests either to an INIT output or to the CPU reset output.

The pulse length is derived from a clock-frequency parameter. It targets 1.75 ms, so it lands inside the allowed window of 1.5 ms to 2.0 ms. A processor reset request produces a short, fixed-length active-low pulse on whichever output the select picks. A trigger write made while the long pulse is running is dropped.

Top module: `swrst_ctrl`

## Requirements
- R1: After reset the register reads 00h at offset REG_OFFSET (default 47h), and pci_rst_no, cpu_rst_no and init_no are all high.
- R2: Bit 0 is the trigger. It is write-only and always reads as 0.
- R3: A write to REG_OFFSET with bit 0 set, made while no pulse is active, drives pci_rst_no low from the next clock edge for exactly PULSE_CYC = CLK_FREQ_HZ*7/4000 cycles. This width lies between CLK_FREQ_HZ*3/2000 and CLK_FREQ_HZ/500 cycles, which is 1.5 ms to 2.0 ms.
- R4: For as long as pci_rst_no is low from a trigger, cpu_rst_no is also low, for the same number of cycles.
- R5: A trigger write made while the pulse is active is ignored. The pulse keeps its original end cycle.
- R6: Bit 7 is read-write. When it is 1, a one-cycle strobe on cpu_rst_req_i drives init_no low for exactly SHORT_CYC cycles, starting at the next edge, and cpu_rst_no stays high.
- R7: When bit 7 is 0, a strobe on cpu_rst_req_i drives cpu_rst_no low for SHORT_CYC cycles, and init_no stays high.
- R8: Bit 6 is read-write, and dt_en_o follows its stored value from the edge after the write.
- R9: Bits 5 to 1 always read as 0.
- R10: Writes to any other offset change nothing. Reads of any other offset return 00h.
- R11: A request strobe that arrives while its routed short pulse is active is ignored. No extra cycles are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CLK_FREQ_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration offset |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i (combinational) |
| cpu_rst_req_i | input | 1 | Processor reset request strobe |
| dt_en_o | output | 1 | Delayed-transaction enable flag |
| pci_rst_no | output | 1 | PCI reset, active low |
| cpu_rst_no | output | 1 | CPU reset, active low |
| init_no | output | 1 | Processor INIT, active low |

## Verification
The assertions assume several things about the inputs. cfg_we_i, cfg_addr_i and cfg_wdata_i are free of X at every clock edge. cpu_rst_req_i is a one-cycle strobe. No routed request overlaps a triggered pulse on the CPU reset output, because overlapping would merge the two low periods. The stimulus keeps within these limits: it changes inputs only on falling edges, raises each request for a single cycle, and waits for every pulse to finish before starting an unrelated scenario. A shortened CLK_FREQ_HZ keeps the long pulse to tens of cycles.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int TRIG_BIT = 0;
  localparam int DTEN_BIT = 6;
  localparam int CSEL_BIT = 7;

  typedef struct packed {
    logic cpu_sel;
    logic dt_en;
  } swrst_ctrl_t;

  typedef enum logic {
    ROUTE_CPU  = 1'b0,
    ROUTE_INIT = 1'b1
  } route_e;
endpackage

// File: rtl/swrst_cfg_reg.sv
module swrst_cfg_reg
  import swrst_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_OFFSET = 8'h47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          trig_o,
  output swrst_ctrl_t   ctrl_o
);
  logic hit;
  swrst_ctrl_t ctrl_q;

  assign hit = (addr_i == REG_OFFSET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i && hit) begin
      ctrl_q.cpu_sel <= wdata_i[CSEL_BIT];
      ctrl_q.dt_en   <= wdata_i[DTEN_BIT];
    end
  end

  // trigger is not stored: it reads back as 0
  assign trig_o = we_i && hit && wdata_i[TRIG_BIT];

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[CSEL_BIT] = ctrl_q.cpu_sel;
      rdata_o[DTEN_BIT] = ctrl_q.dt_en;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/swrst_pulse_timer.sv
module swrst_pulse_timer #(
  parameter int LEN = 4,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  // start while active is dropped: no restart, no extension
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i && !active_o) begin
      cnt_q <= CW'(LEN);
    end else if (active_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/swrst_req_router.sv
module swrst_req_router
  import swrst_pkg::*;
(
  input  logic   req_i,
  input  route_e route_i,
  output logic [1:0] start_o   // [0] cpu reset, [1] init
);
  always_comb begin
    start_o = '0;
    start_o[route_i == ROUTE_INIT] = req_i;
  end
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int SHORT_CYC   = 4,
  parameter logic [7:0] REG_OFFSET = 8'h47,
  localparam longint PULSE_RAW = (longint'(CLK_FREQ_HZ) * 7) / 4000,
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : int'(PULSE_RAW)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       cpu_rst_req_i,
  output logic       dt_en_o,
  output logic       pci_rst_no,
  output logic       cpu_rst_no,
  output logic       init_no
);
  logic        trig;
  swrst_ctrl_t ctrl;
  logic        sw_active;
  logic [1:0]  route_start;
  logic [1:0]  route_active;

  swrst_cfg_reg #(.AW(8), .DW(8), .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .trig_o  (trig),
    .ctrl_o  (ctrl)
  );

  swrst_pulse_timer #(.LEN(PULSE_CYC)) u_sw_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (trig),
    .active_o (sw_active)
  );

  swrst_req_router u_router (
    .req_i   (cpu_rst_req_i),
    .route_i (route_e'(ctrl.cpu_sel)),
    .start_o (route_start)
  );

  for (genvar g = 0; g < 2; g++) begin : g_short
    swrst_pulse_timer #(.LEN(SHORT_CYC)) u_short (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (route_start[g]),
      .active_o (route_active[g])
    );
  end

  assign dt_en_o    = ctrl.dt_en;
  assign pci_rst_no = ~sw_active;
  assign cpu_rst_no = ~(sw_active | route_active[0]);
  assign init_no    = ~route_active[1];
endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk #(
  parameter int PULSE_CYC = 4,
  parameter logic [7:0] REG_OFFSET = 8'h47
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [7:0] cfg_addr_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       dt_en_o,
  input logic       pci_rst_no,
  input logic       cpu_rst_no
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_run_q <= '0;
    else if (!pci_rst_no) low_run_q <= low_run_q + 1;
    else                 low_run_q <= '0;
  end

  assert_trig_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[0] == 1'b0);

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[5:1] == 5'd0);

  assert_trig_starts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == REG_OFFSET && cfg_wdata_i[0] && pci_rst_no) |=> !pci_rst_no);

  assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_rst_no) |-> (low_run_q == PULSE_CYC));

  assert_no_extend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run_q <= PULSE_CYC);

  assert_cpu_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pci_rst_no |-> !cpu_rst_no);

  assert_dt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == REG_OFFSET) |=> (dt_en_o == $past(cfg_wdata_i[6])));

  assert_other_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i != REG_OFFSET) |-> (cfg_rdata_o == 8'h00));

  assert_dt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_addr_i == REG_OFFSET) |=> $stable(dt_en_o));
endmodule

bind swrst_ctrl swrst_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .dt_en_o     (dt_en_o),
  .pci_rst_no  (pci_rst_no),
  .cpu_rst_no  (cpu_rst_no)
);

// File: tb/tb_swrst_ctrl.sv
`timescale 1ns/1ps
module tb_swrst_ctrl;
  localparam int FREQ  = 40_000;            // 1.75 ms -> 70 cycles
  localparam int PCYC  = FREQ * 7 / 4000;
  localparam int PMIN  = FREQ * 3 / 2000;
  localparam int PMAX  = FREQ / 500;
  localparam int SCYC  = 4;
  localparam logic [7:0] OFF = 8'h47;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic cpu_rst_req_i = 1'b0;
  logic dt_en_o, pci_rst_no, cpu_rst_no, init_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_pci_q[$];
  int exp_cpu_q[$];
  int exp_init_q[$];

  always #2.5 clk = ~clk;

  swrst_ctrl #(.CLK_FREQ_HZ(FREQ), .SHORT_CYC(SCYC), .REG_OFFSET(OFF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .cpu_rst_req_i(cpu_rst_req_i),
    .dt_en_o(dt_en_o), .pci_rst_no(pci_rst_no), .cpu_rst_no(cpu_rst_no), .init_no(init_no)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_wdata_i = '0;
  endtask

  task automatic cfg_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr_i = a;
    #1;
    check(req, int'(cfg_rdata_o), int'(exp));
  endtask

  task automatic trigger(input bit expect_pulse);
    if (expect_pulse) begin
      exp_pci_q.push_back(PCYC);
      exp_cpu_q.push_back(PCYC);
    end
    cfg_write(OFF, {dut_sel, dut_dt, 6'b000001});
  endtask

  // shadow of bits 7/6 as the bench itself wrote them
  logic dut_sel = 1'b0;
  logic dut_dt  = 1'b0;

  task automatic request(input bit expect_pulse);
    if (expect_pulse) begin
      if (dut_sel) exp_init_q.push_back(SCYC);
      else         exp_cpu_q.push_back(SCYC);
    end
    @(negedge clk);
    cpu_rst_req_i = 1'b1;
    @(negedge clk);
    cpu_rst_req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitors: measure low pulses and compare with expected widths
  int pci_run = 0, cpu_run = 0, init_run = 0;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (!pci_rst_no) pci_run++;
      else if (pci_run > 0) begin
        if (exp_pci_q.size() == 0) check("R3 unexpected pci pulse", pci_run, 0);
        else begin
          check("R3/R5 pci width", pci_run, exp_pci_q.pop_front());
          checks++;
          if (pci_run < PMIN || pci_run > PMAX) begin
            errors++;
            $display("FAIL R3 window: actual %0d expected %0d..%0d", pci_run, PMIN, PMAX);
          end
        end
        pci_run = 0;
      end
      if (!cpu_rst_no) cpu_run++;
      else if (cpu_run > 0) begin
        if (exp_cpu_q.size() == 0) check("R4/R7 unexpected cpu pulse", cpu_run, 0);
        else check("R4/R7 cpu width", cpu_run, exp_cpu_q.pop_front());
        cpu_run = 0;
      end
      if (!init_no) init_run++;
      else if (init_run > 0) begin
        if (exp_init_q.size() == 0) check("R6 unexpected init pulse", init_run, 0);
        else check("R6/R11 init width", init_run, exp_init_q.pop_front());
        init_run = 0;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 pci_rst_no in reset", int'(pci_rst_no), 1);
    check("R1 cpu_rst_no in reset", int'(cpu_rst_no), 1);
    check("R1 init_no in reset", int'(init_no), 1);
    @(negedge clk); rst_ni = 1'b1;
    cfg_read_check("R1 reset value", OFF, 8'h00);

    // R2/R9 write all ones: bit0 and reserved read 0
    dut_sel = 1'b1; dut_dt = 1'b1;
    exp_pci_q.push_back(PCYC); exp_cpu_q.push_back(PCYC);
    cfg_write(OFF, 8'hFF);
    cfg_read_check("R2/R9 readback after FFh", OFF, 8'hC0);
    check("R8 dt_en_o set", int'(dt_en_o), 1);
    idle(PCYC + 10);

    // R8 clear dt, keep sel 1; plain write no trigger
    dut_dt = 1'b0;
    cfg_write(OFF, 8'h80);
    check("R8 dt_en_o cleared", int'(dt_en_o), 0);
    cfg_read_check("R6 sel readback", OFF, 8'h80);

    // R10 other offsets
    cfg_write(8'h46, 8'hFF);
    cfg_read_check("R10 reg unchanged", OFF, 8'h80);
    check("R10 no pulse from other offset", int'(pci_rst_no), 1);
    cfg_read_check("R10 other offset reads 0", 8'h46, 8'h00);
    cfg_addr_i = OFF;

    // R3/R4 triggered pulse
    trigger(1'b1);
    cfg_read_check("R2 trigger reads 0", OFF, 8'h80);
    // R5 retrigger during pulse
    idle(20);
    trigger(1'b0);
    idle(PCYC);
    check("R5 pulse ended on time", int'(pci_rst_no), 1);
    idle(10);

    // R6 routed to init, R11 repeat request ignored
    request(1'b1);
    check("R6 cpu stays high", int'(cpu_rst_no), 1);
    request(1'b0);
    idle(10);

    // R7 routed to cpu reset
    dut_sel = 1'b0;
    cfg_write(OFF, 8'h00);
    request(1'b1);
    check("R7 init stays high", int'(init_no), 1);
    idle(10);

    check("R3 pci queue drained", exp_pci_q.size(), 0);
    check("R4/R7 cpu queue drained", exp_cpu_q.size(), 0);
    check("R6 init queue drained", exp_init_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule